// File: doc/BRIEF.md
# Host-to-Coprocessor Command Mailbox

This block is the register window through which a host processor hands commands to a management coprocessor and collects the results. The host reaches it over a simple 32-bit register bus with a byte address. The window is 0x100 bytes and contains these locations:

- a write-only command word, whose write rings a doorbell toward the coprocessor;
- a read-only status word that reports progress;
- a 16-byte payload area that the host fills and the coprocessor reads;
- a 16-byte reply area that the coprocessor fills and the host reads, either as whole words or as single bytes.

The coprocessor side sees the latched command and the payload. It loads reply words through a write port. It finishes a command with a done strobe that carries an error flag and an 8-bit error code. The host polls the busy flag until it clears and then reads the error flag. If the command asked for it, the host can instead wait for a one-cycle completion interrupt, which needs no acknowledge.

Top module: `ipc_mailbox`

## Requirements
- R1: After reset, busy, error, overrun, command id and error code read 0, the status initiator field holds the `INIT_ID` parameter, and `cp_doorbell` and `host_irq` are low.
- R2: A host write to offset 0x00 while not busy is accepted. In the cycle after the write edge, `cp_doorbell` is high for exactly one cycle, busy is 1 and `cp_cmd` holds the written word. Acceptance also clears the error flag, the error code and the overrun bit.
- R3: The command word is decoded as opcode in bits 7:0, interrupt request flag in bit 8, sub-command id in bits 15:12 and payload size in bits 23:16. Bits 11:9 and 31:24 are stored in `cp_cmd` but have no other effect.
- R4: The status word at offset 0x04 packs these fields: busy in bit 0, error in bit 1, overrun in bit 2, the sub-command id of the last accepted command in bits 7:4, `INIT_ID` in bits 15:8 and the error code in bits 23:16. Bit 3 and bits 31:24 read 0.
- R5: `cp_done` while busy clears busy and latches `cp_err` and `cp_err_code` on the same edge. `cp_done` while not busy changes nothing.
- R6: On the edge that completes a command whose bit 8 was 1, `host_irq` rises for exactly one cycle. A command with bit 8 at 0 never raises it.
- R7: A command write while busy is dropped: there is no doorbell, and `cp_cmd` and the status command id stay unchanged. The write sets overrun (status bit 2), which stays 1 through completion until the next accepted command.
- R8: Host word writes to offsets 0x80, 0x84, 0x88 and 0x8C land in payload word 0 to 3. Payload word i appears on `cp_obuf` bits 32i+31:32i.
- R9: A `cp_rsp_we` pulse stores `cp_rsp_data` in reply word `cp_rsp_idx`. A host read at 0x90+4i+b returns reply word i shifted right by 8b bits, so the addressed byte is in bits 7:0. Host writes to the reply area have no effect.
- R10: Read data is registered and valid in the cycle after `host_rd`. The command word, the payload area and every unmapped offset read as 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| host_addr | input | 8 | Host byte address in the window |
| host_wr | input | 1 | Host write strobe |
| host_wdata | input | 32 | Host write data |
| host_rd | input | 1 | Host read strobe |
| host_rdata | output | 32 | Registered host read data |
| host_irq | output | 1 | One-cycle completion interrupt |
| cp_doorbell | output | 1 | One-cycle pulse on an accepted command |
| cp_cmd | output | 32 | Last accepted command word |
| cp_obuf | output | 128 | Payload words, word 0 in the low bits |
| cp_rsp_we | input | 1 | Reply word write strobe |
| cp_rsp_idx | input | 2 | Reply word index |
| cp_rsp_data | input | 32 | Reply word data |
| cp_done | input | 1 | Command completion strobe |
| cp_err | input | 1 | Error flag posted with done |
| cp_err_code | input | 8 | Error code posted with done |

## Verification
The bench builds the block with four buffer words and an initiator id of 0xA7. With these values every byte lane of both 16-byte areas can be reached, and the initiator field can be told apart from zero and from the command-id field next to it.

A table of six commands mixes the interrupt flag, sub-command ids from 0 to 15, set reserved bits, and error flags and codes. Each command is run through doorbell, completion, interrupt and status readback. Directed tests then cover the following:

- overrun while busy, and that the overrun bit persists past completion;
- a done strobe while idle;
- byte-offset reads of the reply area;
- ignored host writes to the reply area;
- zero reads of the write-only and unmapped locations.

// File: rtl/mbx_pkg.sv
package mbx_pkg;

  localparam int unsigned WORD_W = 32;

  localparam logic [7:0] OFS_CMD  = 8'h00;
  localparam logic [7:0] OFS_STAT = 8'h04;
  localparam logic [3:0] SEG_OUT  = 4'h8;   // 0x80..0x8F
  localparam logic [3:0] SEG_IN   = 4'h9;   // 0x90..0x9F

  typedef struct packed {
    logic [7:0] rsvd_hi;
    logic [7:0] size;
    logic [3:0] sub_id;
    logic [2:0] rsvd_lo;
    logic       want_irq;
    logic [7:0] opcode;
  } cmd_word_t;

  // Status word packing.
  function automatic logic [31:0] pack_status(input logic busy, input logic err,
                                              input logic ovr, input logic [3:0] id,
                                              input logic [7:0] init_id,
                                              input logic [7:0] code);
    pack_status = {8'h00, code, init_id, id, 1'b0, ovr, err, busy};
  endfunction

  // Byte-lane shift for sub-word reads of the reply area.
  function automatic logic [31:0] lane_shift(input logic [31:0] word, input logic [1:0] lane);
    lane_shift = word >> {lane, 3'b000};
  endfunction

endpackage

// File: rtl/mbx_wbuf.sv
module mbx_wbuf #(
  parameter int unsigned WORDS = 4,
  localparam int unsigned IDX_W = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic                   we,
  input  logic [IDX_W-1:0]       idx,
  input  logic [31:0]            wdata,
  output logic [WORDS*32-1:0]    flat
);

  for (genvar g = 0; g < WORDS; g++) begin : g_word
    logic [31:0] word_q;
    always_ff @(posedge clk) begin
      if (!rst_n)
        word_q <= '0;
      else if (we && (idx == IDX_W'(g)))
        word_q <= wdata;
    end
    assign flat[g*32 +: 32] = word_q;
  end

endmodule

// File: rtl/mbx_ctrl.sv
module mbx_ctrl
  import mbx_pkg::*;
#(
  parameter logic [7:0] INIT_ID = 8'h00
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        cmd_wr,
  input  logic [31:0] cmd_wdata,
  input  logic        cp_done,
  input  logic        cp_err,
  input  logic [7:0]  cp_err_code,
  output logic        busy,
  output logic        overrun,
  output logic [31:0] status,
  output logic [31:0] cmd_q,
  output logic        doorbell,
  output logic        irq,
  output logic        accept_ev,
  output logic        reject_ev,
  output logic        finish_ev
);

  cmd_word_t   cw;
  logic        err_q;
  logic [3:0]  id_q;
  logic [7:0]  code_q;
  logic        ioc_q;

  assign cw        = cmd_word_t'(cmd_wdata);
  assign accept_ev = cmd_wr & ~busy;
  assign reject_ev = cmd_wr & busy;
  assign finish_ev = cp_done & busy;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      busy     <= 1'b0;
      err_q    <= 1'b0;
      overrun  <= 1'b0;
      id_q     <= '0;
      code_q   <= '0;
      ioc_q    <= 1'b0;
      cmd_q    <= '0;
      doorbell <= 1'b0;
      irq      <= 1'b0;
    end else begin
      doorbell <= accept_ev;
      irq      <= finish_ev & ioc_q;
      if (accept_ev) begin
        busy    <= 1'b1;
        err_q   <= 1'b0;
        code_q  <= '0;
        overrun <= 1'b0;
        id_q    <= cw.sub_id;
        ioc_q   <= cw.want_irq;
        cmd_q   <= cmd_wdata;
      end else if (reject_ev) begin
        overrun <= 1'b1;
      end
      if (finish_ev) begin
        busy   <= 1'b0;
        err_q  <= cp_err;
        code_q <= cp_err_code;
      end
    end
  end

  assign status = pack_status(busy, err_q, overrun, id_q, INIT_ID, code_q);

endmodule

// File: rtl/ipc_mailbox.sv
module ipc_mailbox
  import mbx_pkg::*;
#(
  parameter int unsigned WORDS   = 4,
  parameter logic [7:0]  INIT_ID = 8'h01,
  localparam int unsigned IDX_W  = (WORDS > 1) ? $clog2(WORDS) : 1
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [7:0]           host_addr,
  input  logic                 host_wr,
  input  logic [31:0]          host_wdata,
  input  logic                 host_rd,
  output logic [31:0]          host_rdata,
  output logic                 host_irq,
  output logic                 cp_doorbell,
  output logic [31:0]          cp_cmd,
  output logic [WORDS*32-1:0]  cp_obuf,
  input  logic                 cp_rsp_we,
  input  logic [IDX_W-1:0]     cp_rsp_idx,
  input  logic [31:0]          cp_rsp_data,
  input  logic                 cp_done,
  input  logic                 cp_err,
  input  logic [7:0]           cp_err_code
);

  logic              hit_cmd, hit_stat, hit_out, hit_in;
  logic              busy, overrun, accept_ev, reject_ev, finish_ev;
  logic [31:0]       status;
  logic [WORDS*32-1:0] ibuf_flat;
  logic [IDX_W-1:0]  host_idx;
  logic [31:0]       in_word;
  logic [31:0]       rd_next;

  assign hit_cmd  = host_addr[7:2] == OFS_CMD[7:2];
  assign hit_stat = host_addr[7:2] == OFS_STAT[7:2];
  assign hit_out  = host_addr[7:4] == SEG_OUT;
  assign hit_in   = host_addr[7:4] == SEG_IN;
  assign host_idx = IDX_W'(host_addr[3:2]);

  mbx_ctrl #(.INIT_ID(INIT_ID)) u_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .cmd_wr     (host_wr & hit_cmd),
    .cmd_wdata  (host_wdata),
    .cp_done    (cp_done),
    .cp_err     (cp_err),
    .cp_err_code(cp_err_code),
    .busy       (busy),
    .overrun    (overrun),
    .status     (status),
    .cmd_q      (cp_cmd),
    .doorbell   (cp_doorbell),
    .irq        (host_irq),
    .accept_ev  (accept_ev),
    .reject_ev  (reject_ev),
    .finish_ev  (finish_ev)
  );

  mbx_wbuf #(.WORDS(WORDS)) u_obuf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (host_wr & hit_out),
    .idx  (host_idx),
    .wdata(host_wdata),
    .flat (cp_obuf)
  );

  mbx_wbuf #(.WORDS(WORDS)) u_ibuf (
    .clk  (clk),
    .rst_n(rst_n),
    .we   (cp_rsp_we),
    .idx  (cp_rsp_idx),
    .wdata(cp_rsp_data),
    .flat (ibuf_flat)
  );

  always_comb begin
    in_word = '0;
    for (int i = 0; i < int'(WORDS); i++)
      if (host_idx == IDX_W'(i)) in_word = ibuf_flat[i*32 +: 32];
  end

  always_comb begin
    rd_next = '0;
    if (hit_stat)    rd_next = status;
    else if (hit_in) rd_next = lane_shift(in_word, host_addr[1:0]);
  end

  always_ff @(posedge clk) begin
    if (!rst_n)       host_rdata <= '0;
    else if (host_rd) host_rdata <= rd_next;
  end

endmodule

// File: rtl/mbx_checker.sv
module mbx_checker (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        overrun,
  input logic        accept_ev,
  input logic        reject_ev,
  input logic        finish_ev,
  input logic        cp_doorbell,
  input logic        host_irq,
  input logic [31:0] cp_cmd
);

  // R2: doorbell only with busy set, and only for one cycle
  assert_doorbell_busy_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cp_doorbell |-> busy);
  assert_doorbell_pulse_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cp_doorbell |=> !cp_doorbell);
  assert_accept_sets_R2: assert property (@(posedge clk) disable iff (!rst_n)
    accept_ev |=> (busy && cp_doorbell));
  // R5: completion clears busy
  assert_finish_clears_R5: assert property (@(posedge clk) disable iff (!rst_n)
    finish_ev |=> !busy);
  // R6: interrupt is a single pulse, raised only when idle
  assert_irq_pulse_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |=> !host_irq);
  assert_irq_idle_R6: assert property (@(posedge clk) disable iff (!rst_n)
    host_irq |-> !busy);
  // R7: rejected write leaves command alone and flags overrun
  assert_reject_R7: assert property (@(posedge clk) disable iff (!rst_n)
    reject_ev |=> (overrun && !cp_doorbell && $stable(cp_cmd)));

endmodule

bind ipc_mailbox mbx_checker u_mbx_checker (
  .clk        (clk),
  .rst_n      (rst_n),
  .busy       (busy),
  .overrun    (overrun),
  .accept_ev  (accept_ev),
  .reject_ev  (reject_ev),
  .finish_ev  (finish_ev),
  .cp_doorbell(cp_doorbell),
  .host_irq   (host_irq),
  .cp_cmd     (cp_cmd)
);

// File: tb/ipc_mailbox_bench.sv
module ipc_mailbox_bench;

  localparam int CLK_PERIOD = 10;
  localparam logic [7:0] IID = 8'hA7;
  localparam int NV = 6;
  // {command word, error flag, error code}
  localparam logic [40:0] VEC [0:NV-1] = '{
    {32'h0002_11FF, 1'b0, 8'h00},
    {32'h0004_20F4, 1'b1, 8'h5A},
    {32'h0010_F1EF, 1'b1, 8'hFF},
    {32'hFF08_0EF8, 1'b0, 8'h33},
    {32'h0003_91FE, 1'b0, 8'h00},
    {32'h0000_C0A5, 1'b1, 8'h01}
  };

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  host_addr = '0;
  logic        host_wr = 1'b0;
  logic [31:0] host_wdata = '0;
  logic        host_rd = 1'b0;
  logic [31:0] host_rdata;
  logic        host_irq;
  logic        cp_doorbell;
  logic [31:0] cp_cmd;
  logic [127:0] cp_obuf;
  logic        cp_rsp_we = 1'b0;
  logic [1:0]  cp_rsp_idx = '0;
  logic [31:0] cp_rsp_data = '0;
  logic        cp_done = 1'b0;
  logic        cp_err = 1'b0;
  logic [7:0]  cp_err_code = '0;

  int tests = 0;
  int fails = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  ipc_mailbox #(.WORDS(4), .INIT_ID(IID)) u_ipc_mailbox (.*);

  task automatic chk(input string req, input logic [127:0] act, input logic [127:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic hwr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); host_addr = a; host_wdata = d; host_wr = 1'b1;
    @(negedge clk); host_wr = 1'b0;
  endtask

  task automatic hrd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); host_addr = a; host_rd = 1'b1;
    @(negedge clk); host_rd = 1'b0; d = host_rdata;
  endtask

  task automatic finish_cmd(input logic e, input logic [7:0] c);
    @(negedge clk); cp_done = 1'b1; cp_err = e; cp_err_code = c;
    @(negedge clk); cp_done = 1'b0;
  endtask

  task automatic rsp(input logic [1:0] i, input logic [31:0] d);
    @(negedge clk); cp_rsp_we = 1'b1; cp_rsp_idx = i; cp_rsp_data = d;
    @(negedge clk); cp_rsp_we = 1'b0;
  endtask

  function automatic logic [31:0] exp_stat(input logic b, input logic e, input logic o,
                                           input logic [3:0] id, input logic [7:0] code);
    logic [31:0] s;
    s = '0;
    s[0] = b; s[1] = e; s[2] = o;
    s[7:4] = id; s[15:8] = IID; s[23:16] = code;
    return s;
  endfunction

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

  initial begin : main
    logic [31:0] r;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    chk("R1 doorbell", 128'(cp_doorbell), 128'(0));
    chk("R1 irq", 128'(host_irq), 128'(0));
    hrd(8'h04, r);
    chk("R1 status", 128'(r), 128'(exp_stat(0, 0, 0, 4'h0, 8'h00)));

    // R2 R3 R4 R5 R6 vector walk
    for (int v = 0; v < NV; v++) begin
      logic [31:0] cw;
      logic e;
      logic [7:0] c;
      cw = VEC[v][40:9]; e = VEC[v][8]; c = VEC[v][7:0];
      hwr(8'h00, cw);
      chk("R2 doorbell high", 128'(cp_doorbell), 128'(1));
      chk("R2 cp_cmd", 128'(cp_cmd), 128'(cw));
      hrd(8'h04, r);
      chk("R2 doorbell one cycle", 128'(cp_doorbell), 128'(0));
      chk("R4 busy status", 128'(r), 128'(exp_stat(1, 0, 0, cw[15:12], 8'h00)));
      finish_cmd(e, c);
      chk("R6 irq on completion", 128'(host_irq), 128'(cw[8]));
      @(negedge clk);
      chk("R6 irq single cycle", 128'(host_irq), 128'(0));
      hrd(8'h04, r);
      chk("R5 R3 done status", 128'(r), 128'(exp_stat(0, e, 0, cw[15:12], c)));
    end

    // R5 done while idle is ignored
    finish_cmd(1'b0, 8'h77);
    chk("R5 idle done irq", 128'(host_irq), 128'(0));
    hrd(8'h04, r);
    chk("R5 idle done status", 128'(r), 128'(exp_stat(0, 1, 0, 4'hC, 8'h01)));

    // R7 overrun
    hwr(8'h00, 32'h0000_3111);
    hwr(8'h00, 32'h0000_5022);
    chk("R7 no doorbell", 128'(cp_doorbell), 128'(0));
    chk("R7 cmd kept", 128'(cp_cmd), 128'(32'h0000_3111));
    hrd(8'h04, r);
    chk("R7 overrun status", 128'(r), 128'(exp_stat(1, 0, 1, 4'h3, 8'h00)));
    finish_cmd(1'b0, 8'h00);
    chk("R7 R6 irq", 128'(host_irq), 128'(1));
    hrd(8'h04, r);
    chk("R7 overrun sticky", 128'(r), 128'(exp_stat(0, 0, 1, 4'h3, 8'h00)));
    hwr(8'h00, 32'h0000_6000);
    hrd(8'h04, r);
    chk("R7 overrun cleared", 128'(r), 128'(exp_stat(1, 0, 0, 4'h6, 8'h00)));
    finish_cmd(1'b0, 8'h00);
    chk("R6 no irq without flag", 128'(host_irq), 128'(0));

    // R8 payload buffer
    hwr(8'h80, 32'h0A0B_0C0D);
    hwr(8'h84, 32'h1111_2222);
    hwr(8'h88, 32'hDEAD_BEEF);
    hwr(8'h8C, 32'h5566_7788);
    chk("R8 cp_obuf", cp_obuf, {32'h5566_7788, 32'hDEAD_BEEF, 32'h1111_2222, 32'h0A0B_0C0D});
    hrd(8'h84, r);
    chk("R10 payload reads zero", 128'(r), 128'(0));
    hrd(8'h00, r);
    chk("R10 command reads zero", 128'(r), 128'(0));
    hrd(8'h40, r);
    chk("R10 unmapped reads zero", 128'(r), 128'(0));

    // R9 reply buffer
    rsp(2'd0, 32'h4433_2211);
    rsp(2'd1, 32'h8877_6655);
    rsp(2'd3, 32'hCAFE_F00D);
    hrd(8'h90, r);
    chk("R9 word0", 128'(r), 128'(32'h4433_2211));
    hrd(8'h94, r);
    chk("R9 word1", 128'(r), 128'(32'h8877_6655));
    hrd(8'h91, r);
    chk("R9 byte 0x91", 128'(r[7:0]), 128'(8'h22));
    hrd(8'h93, r);
    chk("R9 byte 0x93", 128'(r), 128'(32'h0000_0044));
    hrd(8'h9E, r);
    chk("R9 byte 0x9E", 128'(r[7:0]), 128'(8'hFE));
    hwr(8'h94, 32'h0123_4567);
    hrd(8'h94, r);
    chk("R9 host write ignored", 128'(r), 128'(32'h8877_6655));
    chk("R9 host write no payload", cp_obuf[63:32], 128'(32'h1111_2222));

    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end

endmodule